// File: doc/BRIEF.md
# CAN Error Warning Flag Generator

This block sits beside the fault-confinement counters of a CAN controller. It raises a transmit warning flag and a receive warning flag, and it drives one combined warning interrupt. Each flag sets when its error counter climbs from below the warning threshold (96 by default) to the threshold or above. Each flag stays set until software clears it through a one-cycle write-one-to-clear strobe. A warning-enable input gates the whole function. While the enable is low, both flags and the interrupt read 0, and any held flag state is dropped.

Each counter channel has two parts. A crossing detector registers the previous counter value and compares it with the current value. A two-state flag machine takes the detector's output. The machine has the states `WARN_IDLE` and `WARN_RAISED`. It has four transitions:
- **raise** (IDLE to RAISED): an upward crossing while the enable is high.
- **ack** (RAISED to IDLE): a clear strobe with no crossing in the same cycle.
- **drop** (RAISED to IDLE): the enable goes low.
- **hold** (stay in RAISED): no clear, or a clear and a crossing arrive together.

The two channels are identical instances made by a generate loop.

Top module: `can_warn_flags`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `tx_warn`, `rx_warn` and `warn_irq` are 0. The stored previous counter values reset to 0.
- R2: With `warn_en` = 1, if the previous `tx_err_cnt` was below THRESH and the current value is at least THRESH, `tx_warn` reads 1 after that clock edge.
- R3: The receive channel behaves the same way as R2, using `rx_err_cnt` and `rx_warn`. The two channels do not affect each other.
- R4: A counter that stays at or above THRESH never sets its flag again. A new set needs the counter to fall below THRESH and then cross upward again.
- R5: A set flag stays at 1 until its clear strobe (`tx_clr` or `rx_clr`) is 1 at a clock edge. After that edge the flag reads 0.
- R6: If a crossing and the clear strobe of the same channel occur at the same edge, the flag reads 1 after that edge.
- R7: While `warn_en` = 0, `tx_warn`, `rx_warn` and `warn_irq` read 0 in the same cycle. Held flag state is discarded, and crossings that occur while disabled are not recorded.
- R8: If `warn_en` rises while a counter is already at or above THRESH, that flag stays 0 until a new upward crossing occurs.
- R9: `warn_irq` is 1 exactly when `warn_en` = 1 and at least one of `tx_warn` or `rx_warn` is 1.
- R10: A jump over the threshold counts as a crossing, for example 95 to 102. A counter that dropped below THRESH and then returns to THRESH sets the flag again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| warn_en | input | 1 | Warning enable; 0 forces flags and interrupt to 0 |
| tx_err_cnt | input | CW (8) | Transmit error counter value |
| rx_err_cnt | input | CW (8) | Receive error counter value |
| tx_clr | input | 1 | Write-one-to-clear strobe for the transmit flag |
| rx_clr | input | 1 | Write-one-to-clear strobe for the receive flag |
| tx_warn | output | 1 | Transmit warning flag |
| rx_warn | output | 1 | Receive warning flag |
| warn_irq | output | 1 | Combined warning interrupt |

## Verification
The hardest situations to reach involve history. One is an enable that rises while a counter is already above the threshold. Another is a crossing that happens while the block is disabled, followed by re-enabling with the counter still high. A third is a clear strobe that lands on the same edge as a fresh crossing. The stimulus table walks the counters through these histories in order: it disables the block, moves the counter across the threshold while disabled, and then re-enables. It also lines up a clear with a new crossing after a dip below the threshold, so each ordering is exercised deliberately rather than by chance.

// File: rtl/can_warn_pkg.sv
package can_warn_pkg;

    typedef enum logic {
        WARN_IDLE   = 1'b0,
        WARN_RAISED = 1'b1
    } warn_state_e;

    localparam int NUM_CH = 2;
    localparam int CH_TX  = 0;
    localparam int CH_RX  = 1;

endpackage

// File: rtl/can_warn_cross.sv
module can_warn_cross #(
    parameter int CW     = 8,
    parameter int THRESH = 96
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    output logic          crossed
);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= count;
        end
    end

    always_comb begin
        crossed = (prev_q < LIMIT) && (count >= LIMIT);
    end
endmodule

// File: rtl/can_warn_flag.sv
module can_warn_flag
    import can_warn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic crossed,
    input  logic clear,
    output logic flag
);
    warn_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WARN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WARN_IDLE: begin
                if (enable && crossed) begin
                    state_d = WARN_RAISED;      // raise
                end
            end
            WARN_RAISED: begin
                if (!enable) begin
                    state_d = WARN_IDLE;        // drop
                end else if (clear && !crossed) begin
                    state_d = WARN_IDLE;        // ack
                end
            end
            default: state_d = WARN_IDLE;
        endcase
    end

    always_comb begin
        flag = enable && (state_q == WARN_RAISED);
    end
endmodule

// File: rtl/can_warn_flags.sv
module can_warn_flags
    import can_warn_pkg::*;
#(
    parameter int CW     = 8,
    parameter int THRESH = 96
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warn_en,
    input  logic [CW-1:0] tx_err_cnt,
    input  logic [CW-1:0] rx_err_cnt,
    input  logic          tx_clr,
    input  logic          rx_clr,
    output logic          tx_warn,
    output logic          rx_warn,
    output logic          warn_irq
);
    logic [NUM_CH-1:0][CW-1:0] cnt_vec;
    logic [NUM_CH-1:0]         clr_vec;
    logic [NUM_CH-1:0]         cross_vec;
    logic [NUM_CH-1:0]         flag_vec;

    always_comb begin
        cnt_vec[CH_TX] = tx_err_cnt;
        cnt_vec[CH_RX] = rx_err_cnt;
        clr_vec[CH_TX] = tx_clr;
        clr_vec[CH_RX] = rx_clr;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        can_warn_cross #(
            .CW     (CW),
            .THRESH (THRESH)
        ) u_cross (
            .clk     (clk),
            .rst_n   (rst_n),
            .count   (cnt_vec[ch]),
            .crossed (cross_vec[ch])
        );

        can_warn_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (warn_en),
            .crossed (cross_vec[ch]),
            .clear   (clr_vec[ch]),
            .flag    (flag_vec[ch])
        );
    end

    always_comb begin
        tx_warn  = flag_vec[CH_TX];
        rx_warn  = flag_vec[CH_RX];
        warn_irq = warn_en && (|flag_vec);
    end
endmodule

// File: rtl/can_warn_flags_chk.sv
module can_warn_flags_chk #(
    parameter int CW     = 8,
    parameter int THRESH = 96
) (
    input logic          clk,
    input logic          rst_n,
    input logic          warn_en,
    input logic [CW-1:0] tx_err_cnt,
    input logic [CW-1:0] rx_err_cnt,
    input logic          tx_clr,
    input logic          rx_clr,
    input logic          tx_warn,
    input logic          rx_warn,
    input logic          warn_irq
);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    // R2: a newly raised transmit flag follows a counter at or above the limit
    assert_tx_set_on_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_warn) |-> ($past(tx_err_cnt) >= LIMIT));

    // R3: same rule for the receive channel
    assert_rx_set_on_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_warn) |-> ($past(rx_err_cnt) >= LIMIT));

    // R5: a raised flag holds without a clear while enabled
    assert_tx_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_warn && !tx_clr) |=> (tx_warn || !warn_en));

    // R5: a clear with no possible crossing empties the flag
    assert_tx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr && (tx_err_cnt < LIMIT)) |=> !tx_warn);

    assert_rx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && (rx_err_cnt < LIMIT)) |=> !rx_warn);

    // R7: disabled block raises no interrupt
    assert_irq_off_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !warn_en |-> !warn_irq);

    // R9: interrupt only with a flag present
    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |-> (tx_warn || rx_warn));
endmodule

bind can_warn_flags can_warn_flags_chk #(
    .CW     (CW),
    .THRESH (THRESH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .warn_en    (warn_en),
    .tx_err_cnt (tx_err_cnt),
    .rx_err_cnt (rx_err_cnt),
    .tx_clr     (tx_clr),
    .rx_clr     (rx_clr),
    .tx_warn    (tx_warn),
    .rx_warn    (rx_warn),
    .warn_irq   (warn_irq)
);

// File: tb/can_warn_flags_test.sv
module can_warn_flags_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       warn_en = 1'b0;
    logic [7:0] tx_err_cnt = '0;
    logic [7:0] rx_err_cnt = '0;
    logic       tx_clr = 1'b0;
    logic       rx_clr = 1'b0;
    logic       tx_warn, rx_warn, warn_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_warn_flags uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .warn_en    (warn_en),
        .tx_err_cnt (tx_err_cnt),
        .rx_err_cnt (rx_err_cnt),
        .tx_clr     (tx_clr),
        .rx_clr     (rx_clr),
        .tx_warn    (tx_warn),
        .rx_warn    (rx_warn),
        .warn_irq   (warn_irq)
    );

    // {tag, tx cnt, rx cnt, en, tx_clr, rx_clr, exp tx, exp rx, exp irq, pad}
    function automatic logic [31:0] vec(int tag, int tc, int rc, bit en, bit ct, bit cr,
                                        bit et, bit er, bit ei);
        return {8'(tag), 8'(tc), 8'(rc), en, ct, cr, et, er, ei, 2'b00};
    endfunction

    localparam logic [31:0] VEC [NV] = '{
        vec(9,   0,  0, 1, 0, 0, 0, 0, 0),   // R9 idle
        vec(2,  95,  0, 1, 0, 0, 0, 0, 0),   // R2 below limit
        vec(2,  96,  0, 1, 0, 0, 1, 0, 1),   // R2 crossing sets
        vec(5,  97,  0, 1, 0, 0, 1, 0, 1),   // R5 holds
        vec(5,  97,  0, 1, 1, 0, 0, 0, 0),   // R5 clear
        vec(4, 100,  0, 1, 0, 0, 0, 0, 0),   // R4 no re-set above
        vec(4,  90,  0, 1, 0, 0, 0, 0, 0),   // R4 dip
        vec(10, 96, 95, 1, 0, 0, 1, 0, 1),   // R10 re-cross
        vec(3,  96,102, 1, 0, 0, 1, 1, 1),   // R3 jump crossing rx
        vec(5,  96,102, 1, 1, 1, 0, 0, 0),   // R5 clear both
        vec(4,  50, 50, 1, 0, 0, 0, 0, 0),   // R4 dip
        vec(6,  96, 50, 1, 1, 0, 1, 0, 1),   // R6 set wins over clear
        vec(7,  96, 50, 0, 0, 0, 0, 0, 0),   // R7 disable
        vec(7,  20, 50, 0, 0, 0, 0, 0, 0),   // R7
        vec(7,  99, 50, 0, 0, 0, 0, 0, 0),   // R7 crossing while disabled
        vec(8,  99, 50, 1, 0, 0, 0, 0, 0),   // R8 enable while high
        vec(8,  99, 50, 1, 0, 0, 0, 0, 0),   // R8 stays low
        vec(3,  80, 80, 1, 0, 0, 0, 0, 0),   // R3
        vec(9,  80, 96, 1, 0, 0, 0, 1, 1),   // R9 irq from rx only
        vec(7,  80, 96, 0, 0, 0, 0, 0, 0),   // R7 drop
        vec(8,  80, 96, 1, 0, 0, 0, 0, 0)    // R8 state discarded
    };

    task automatic check(string req, logic [2:0] got, logic [2:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {tx,rx,irq} got %b expected %b", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {tx_warn, rx_warn, warn_irq}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {tx_warn, rx_warn, warn_irq}, 3'b000);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            string tag;
            v = VEC[i];
            tx_err_cnt = v[23:16];
            rx_err_cnt = v[15:8];
            warn_en    = v[7];
            tx_clr     = v[6];
            rx_clr     = v[5];
            @(posedge clk);
            @(negedge clk);
            tag = $sformatf("R%0d vec %0d", v[31:24], i);
            check(tag, {tx_warn, rx_warn, warn_irq}, v[4:2]);
        end

        // R1: reset while a flag is held clears it
        tx_clr = 0; rx_clr = 0; warn_en = 1;
        tx_err_cnt = 10; rx_err_cnt = 10;
        @(negedge clk);
        tx_err_cnt = 120;
        @(negedge clk);
        check("R1 pre-reset set", {tx_warn, rx_warn, warn_irq}, 3'b101);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", {tx_warn, rx_warn, warn_irq}, 3'b000);
        tx_err_cnt = 50;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after second reset", {tx_warn, rx_warn, warn_irq}, 3'b000);

        // R10: jump over the limit from 95 to 102 on tx
        tx_err_cnt = 95;
        @(negedge clk);
        tx_err_cnt = 102;
        @(negedge clk);
        check("R10 jump crossing", {tx_warn, rx_warn, warn_irq}, 3'b101);

        finish_run();
    end
endmodule